// File: doc/BRIEF.md
# Unit Supply Mode Controller

This block manages power locally for one synchronous island inside a network whose islands run on independent clocks. It keeps the island's supply mode in a small register set that is written over a plain write port. From that mode it decides which supply rail feeds the island: the high rail, the low rail or neither. It drives the enables of the two power switches, the island's reset and its clock-stop request.

Changing rails is never done abruptly. The controller first asks the island's local clock generator to pause and waits for its acknowledge. It then opens both switches for one cycle and closes the new one. It holds the pause for a programmable settle time and then releases it. In the hopping mode a PWM generator keeps swapping the two rails, and its duty value sets the island's average speed and power. A mode write that lands while a rail change is still under way waits until that change has finished.

Top module: `supply_mode_ctrl`

## Requirements
- R1: While reset is active and after its release, the controller is in Init (mode_o = 0) with the high switch closed, the low switch open, unit_rst_no low, unit_clk_stop_o low and pause_req_o low.
- R2: A write with cfg_addr_i = 0 requests a mode. Address 1 sets the PWM period, 2 the PWM duty, 3 the delay-line code and 4 the settle count. The delay-line code appears on dly_code_o one cycle after its write. Writes to addresses 5 to 7 change nothing.
- R3: The mode codes are Init = 0, High = 1, Low = 2, Hopping = 3, Idle = 4 and Off = 5. Once a rail change has completed, Init and High use the high rail and Low and Idle use the low rail. Off opens both switches. unit_rst_no is low in Init and Off, and unit_clk_stop_o is high in Idle and Off.
- R4: sw_high_en_o and sw_low_en_o are never high in the same cycle.
- R5: A switch enable changes only in a cycle in which pause_req_o is high. After pause_req_o rises, no switch changes until pause_ack_i has been seen high.
- R6: Between releasing one rail and closing the other there is exactly one cycle with both switches open.
- R7: With settle count S, the new rail is held for S+1 cycles with pause_req_o still high. pause_req_o then falls.
- R8: A mode written while a rail change is in progress is held and takes effect after that change completes.
- R9: When the controller leaves Off for any mode other than Init, it enters Init first and then the requested mode.
- R10: In Hopping, a counter runs from 0 to period-1 and the high rail is targeted while the count is below duty. A duty of 0 keeps the low rail. A duty of at least the period keeps the high rail.
- R11: A mode write with a code of 6 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| pause_ack_i | input | 1 | Acknowledge from the local clock generator |
| pause_req_o | output | 1 | Clock-pause request |
| sw_high_en_o | output | 1 | High-rail power switch enable |
| sw_low_en_o | output | 1 | Low-rail power switch enable |
| unit_rst_no | output | 1 | Island reset, active low |
| unit_clk_stop_o | output | 1 | Island clock-stop request |
| dly_code_o | output | DATA_W | Delay-line code |
| mode_o | output | 3 | Current supply mode |

## Verification
The bench measures the break gap and the settle window on real rail changes. A design with no break cycle would show a zero-length gap, and one that miscounts the settle time would release the pause one cycle early or late. It withholds the acknowledge while a second mode is written. A design that ignores the acknowledge would switch anyway, and one that drops the pending mode would stop in the first mode. It leaves Off for Low and watches for Init on the way, which catches a controller that jumps straight across. It also counts high-rail cycles in Hopping at two duty settings and at both duty extremes, so a design with an inverted comparison or a wrong counter wrap produces the wrong share of high-rail time.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    M_INIT = 3'd0, M_HIGH = 3'd1, M_LOW = 3'd2,
    M_HOP  = 3'd3, M_IDLE = 3'd4, M_OFF = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    RAIL_NONE = 2'd0, RAIL_HIGH = 2'd1, RAIL_LOW = 2'd2
  } rail_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  // configuration registers live at addresses 1..NCFG
  localparam int unsigned NCFG = 4;
  localparam int unsigned CFG_PERIOD = 0;
  localparam int unsigned CFG_DUTY   = 1;
  localparam int unsigned CFG_DLY    = 2;
  localparam int unsigned CFG_SETTLE = 3;
endpackage

// File: rtl/smc_regs.sv
module smc_regs
  import smc_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PERIOD_RST = 16,
  parameter int unsigned DUTY_RST   = 8,
  parameter int unsigned DLY_RST    = 0,
  parameter int unsigned SETTLE_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] period_o,
  output logic [DATA_W-1:0] duty_o,
  output logic [DATA_W-1:0] dly_o,
  output logic [DATA_W-1:0] settle_o,
  output logic              mode_wr_o,
  output mode_e             mode_wdata_o
);
  localparam logic [DATA_W-1:0] MAX_MODE = DATA_W'(M_OFF);

  logic [DATA_W-1:0] cfg_q [NCFG];

  function automatic logic [DATA_W-1:0] rst_val(input int unsigned idx);
    case (idx)
      CFG_PERIOD: rst_val = DATA_W'(PERIOD_RST);
      CFG_DUTY:   rst_val = DATA_W'(DUTY_RST);
      CFG_DLY:    rst_val = DATA_W'(DLY_RST);
      default:    rst_val = DATA_W'(SETTLE_RST);
    endcase
  endfunction

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    logic wen;
    assign wen = wr_i && (addr_i == ADDR_W'(g + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_q[g] <= rst_val(g);
      else if (wen) cfg_q[g] <= wdata_i;
    end
  end

  assign period_o     = cfg_q[CFG_PERIOD];
  assign duty_o       = cfg_q[CFG_DUTY];
  assign dly_o        = cfg_q[CFG_DLY];
  assign settle_o     = cfg_q[CFG_SETTLE];
  assign mode_wr_o    = wr_i && (addr_i == A_MODE) && (wdata_i <= MAX_MODE);
  assign mode_wdata_o = mode_e'(wdata_i[2:0]);
endmodule

// File: rtl/smc_pwm.sv
module smc_pwm #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DATA_W-1:0] period_i,
  input  logic [DATA_W-1:0] duty_i,
  output logic              phase_high_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              wrap;

  assign wrap = ({1'b0, cnt_q} + (DATA_W+1)'(1)) >= {1'b0, period_i};

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + DATA_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign phase_high_o = cnt_q < duty_i;
endmodule

// File: rtl/smc_rail_seq.sv
module smc_rail_seq
  import smc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rail_e             tgt_i,
  input  logic [DATA_W-1:0] settle_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              sw_high_o,
  output logic              sw_low_o,
  output rail_e             rail_o,
  output logic              steady_o
);
  typedef enum logic [2:0] {
    SQ_STEADY, SQ_REQ, SQ_BREAK, SQ_SETTLE, SQ_DROP
  } seq_e;

  seq_e              st_q, st_d;
  rail_e             rail_q, rail_d, nxt_q, nxt_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    rail_d = rail_q;
    nxt_d  = nxt_q;
    cnt_d  = cnt_q;
    case (st_q)
      SQ_STEADY: if (tgt_i != rail_q) begin
        nxt_d = tgt_i;
        st_d  = SQ_REQ;
      end
      SQ_REQ:    if (ack_i) st_d = SQ_BREAK;
      SQ_BREAK: begin
        rail_d = nxt_q;
        cnt_d  = settle_i;
        st_d   = SQ_SETTLE;
      end
      SQ_SETTLE: if (cnt_q == '0) st_d = SQ_DROP;
                 else             cnt_d = cnt_q - DATA_W'(1);
      SQ_DROP:   if (!ack_i) st_d = SQ_STEADY;
      default:   st_d = SQ_STEADY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_STEADY;
      rail_q <= RAIL_HIGH;
      nxt_q  <= RAIL_HIGH;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      rail_q <= rail_d;
      nxt_q  <= nxt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign req_o     = (st_q == SQ_REQ) || (st_q == SQ_BREAK) || (st_q == SQ_SETTLE);
  assign sw_high_o = (rail_q == RAIL_HIGH) && (st_q != SQ_BREAK);
  assign sw_low_o  = (rail_q == RAIL_LOW)  && (st_q != SQ_BREAK);
  assign rail_o    = rail_q;
  assign steady_o  = (st_q == SQ_STEADY);
endmodule

// File: rtl/smc_mode_fsm.sv
module smc_mode_fsm
  import smc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  mode_e wdata_i,
  input  logic  settled_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d, pend_q, pend_d;
  logic  pend_vld_q, pend_vld_d;

  always_comb begin
    mode_d     = mode_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    if (pend_vld_q && settled_i) begin
      if (mode_q == M_OFF && pend_q != M_OFF && pend_q != M_INIT) begin
        mode_d = M_INIT;              // detour; request stays pending
      end else begin
        mode_d     = pend_q;
        pend_vld_d = 1'b0;
      end
    end
    if (wr_i) begin
      pend_d     = wdata_i;
      pend_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_INIT;
      pend_q     <= M_INIT;
      pend_vld_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/supply_mode_ctrl.sv
module supply_mode_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PERIOD_RST = 16,
  parameter int unsigned DUTY_RST   = 8,
  parameter int unsigned DLY_RST    = 0,
  parameter int unsigned SETTLE_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              pause_ack_i,
  output logic              pause_req_o,
  output logic              sw_high_en_o,
  output logic              sw_low_en_o,
  output logic              unit_rst_no,
  output logic              unit_clk_stop_o,
  output logic [DATA_W-1:0] dly_code_o,
  output logic [2:0]        mode_o
);
  logic              rst_meta_q, rst_n_q;
  logic [DATA_W-1:0] period, duty, settle;
  logic              mode_wr, phase_high, steady, settled;
  mode_e             mode_wdata, mode;
  rail_e             tgt_rail, cur_rail;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  smc_regs #(
    .DATA_W(DATA_W), .PERIOD_RST(PERIOD_RST), .DUTY_RST(DUTY_RST),
    .DLY_RST(DLY_RST), .SETTLE_RST(SETTLE_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n_q), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .period_o(period), .duty_o(duty), .dly_o(dly_code_o),
    .settle_o(settle), .mode_wr_o(mode_wr), .mode_wdata_o(mode_wdata)
  );

  smc_pwm #(.DATA_W(DATA_W)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_n_q), .run_i(mode == M_HOP),
    .period_i(period), .duty_i(duty), .phase_high_o(phase_high)
  );

  always_comb begin
    case (mode)
      M_INIT, M_HIGH: tgt_rail = RAIL_HIGH;
      M_LOW, M_IDLE:  tgt_rail = RAIL_LOW;
      M_HOP:          tgt_rail = phase_high ? RAIL_HIGH : RAIL_LOW;
      default:        tgt_rail = RAIL_NONE;
    endcase
  end

  smc_rail_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_n_q), .tgt_i(tgt_rail), .settle_i(settle),
    .ack_i(pause_ack_i), .req_o(pause_req_o), .sw_high_o(sw_high_en_o),
    .sw_low_o(sw_low_en_o), .rail_o(cur_rail), .steady_o(steady)
  );

  assign settled = steady && (cur_rail == tgt_rail);

  smc_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_n_q), .wr_i(mode_wr), .wdata_i(mode_wdata),
    .settled_i(settled), .mode_o(mode)
  );

  assign mode_o          = mode;
  assign unit_rst_no     = !((mode == M_INIT) || (mode == M_OFF));
  assign unit_clk_stop_o = (mode == M_IDLE) || (mode == M_OFF);
endmodule

// File: rtl/smc_checker.sv
module smc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pause_req,
  input logic       sw_high,
  input logic       sw_low,
  input logic [2:0] mode
);
  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_high && sw_low));

  a_r5_switch_under_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_high != $past(sw_high) || sw_low != $past(sw_low)) |-> (pause_req && $past(pause_req)));

  a_r6_low_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_low) |-> !$past(sw_high));

  a_r6_high_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_high) |-> !$past(sw_low));

  a_r9_off_exit_init: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd5 && mode != 3'd5) |-> mode == 3'd0);

  a_r3_off_open: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && $stable(mode) && !pause_req && !$past(pause_req)) |-> (!sw_high && !sw_low));
endmodule

bind supply_mode_ctrl smc_checker u_chk (
  .clk(clk_i), .rst_n(rst_n_q), .pause_req(pause_req_o),
  .sw_high(sw_high_en_o), .sw_low(sw_low_en_o), .mode(mode_o)
);

// File: tb/tb_supply_mode_ctrl.sv
module tb_supply_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       pause_ack = 1'b0;
  logic       pause_req, sw_h, sw_l, u_rst_n, clk_stop;
  logic [7:0] dly;
  logic [2:0] mode;

  int total = 0, bad = 0;
  bit hold_ack = 1'b0, done = 1'b0, mon_on = 1'b0;
  int both_cnt = 0, bare_cnt = 0, brk_run = 0, set_run = 0;
  int last_brk = -1, last_set = -1;
  bit in_settle = 1'b0, prev_h = 1'b0, prev_l = 1'b0;

  always #5 clk = ~clk;

  supply_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .pause_ack_i(pause_ack), .pause_req_o(pause_req),
    .sw_high_en_o(sw_h), .sw_low_en_o(sw_l), .unit_rst_no(u_rst_n),
    .unit_clk_stop_o(clk_stop), .dly_code_o(dly), .mode_o(mode)
  );

  // clock-generator model: acknowledge follows the request unless withheld
  initial forever begin
    @(negedge clk);
    if (!hold_ack) pause_ack = pause_req;
  end

  // monitor of switch behaviour
  always @(negedge clk) begin
    if (mon_on) begin
      if (sw_h && sw_l) both_cnt++;
      if ((sw_h != prev_h || sw_l != prev_l) && !pause_req) bare_cnt++;
      if (pause_req && !sw_h && !sw_l) brk_run++;
      else begin
        if (brk_run > 0 && pause_req) begin
          last_brk = brk_run; in_settle = 1'b1; set_run = 0;
        end
        brk_run = 0;
      end
      if (in_settle) begin
        if (pause_req) set_run++;
        else begin last_set = set_run; in_settle = 1'b0; end
      end
    end
    prev_h = sw_h; prev_l = sw_l;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_quiet();
    int lows = 0;
    for (int i = 0; i < 400 && lows < 4; i++) begin
      @(negedge clk);
      lows = pause_req ? 0 : lows + 1;
    end
  endtask

  task automatic go_mode(input logic [2:0] m);
    cfg_write(3'd0, {5'd0, m});
    for (int i = 0; i < 400 && mode != m; i++) @(negedge clk);
    wait_quiet();
  endtask

  task automatic t_reset();
    check(mode == 3'd0, "R1 mode", mode, 0);
    check(sw_h && !sw_l, "R1 switches", {sw_h, sw_l}, 2);
    check(!u_rst_n && !clk_stop && !pause_req, "R1 rst/stop/pause",
          {u_rst_n, clk_stop, pause_req}, 0);
  endtask

  task automatic t_regs();
    cfg_write(3'd3, 8'h5A);
    check(dly == 8'h5A, "R2 delay code", dly, 8'h5A);
    cfg_write(3'd7, 8'h11);
    cfg_write(3'd5, 8'h22);
    check(dly == 8'h5A && mode == 3'd0, "R2 unmapped address", dly, 8'h5A);
    cfg_write(3'd4, 8'd2);   // settle count 2
  endtask

  task automatic t_high_low();
    go_mode(3'd1);
    check(mode == 3'd1 && sw_h && !sw_l && u_rst_n, "R3 high mode", {sw_h, sw_l, u_rst_n}, 3'b101);
    last_brk = -1; last_set = -1;
    go_mode(3'd2);
    check(sw_l && !sw_h && !clk_stop, "R3 low mode", {sw_h, sw_l}, 1);
    check(last_brk == 1, "R6 break gap", last_brk, 1);
    check(last_set == 3, "R7 settle window", last_set, 3);
  endtask

  task automatic t_illegal();
    cfg_write(3'd0, 8'd6);
    repeat (6) @(negedge clk);
    check(mode == 3'd2 && sw_l, "R11 code 6 ignored", mode, 2);
    cfg_write(3'd0, 8'd7);
    repeat (6) @(negedge clk);
    check(mode == 3'd2, "R11 code 7 ignored", mode, 2);
  endtask

  task automatic t_pending();
    bit saw_h = 1'b0;
    hold_ack = 1'b1;
    cfg_write(3'd0, 8'd1);
    for (int i = 0; i < 50 && mode != 3'd1; i++) @(negedge clk);
    cfg_write(3'd0, 8'd4);
    repeat (20) @(negedge clk);
    check(pause_req && sw_l && !sw_h, "R5 no switch without ack", {sw_h, sw_l}, 1);
    check(mode == 3'd1, "R8 pending held", mode, 1);
    hold_ack = 1'b0;
    for (int i = 0; i < 400 && mode != 3'd4; i++) begin
      @(negedge clk);
      if (sw_h) saw_h = 1'b1;
    end
    wait_quiet();
    check(saw_h, "R8 first change completed", saw_h, 1);
    check(mode == 3'd4 && sw_l && clk_stop && u_rst_n, "R8 pending applied / R3 idle",
          mode, 4);
  endtask

  task automatic t_off();
    bit saw_init = 1'b0;
    go_mode(3'd5);
    check(!sw_h && !sw_l && !u_rst_n && clk_stop, "R3 off mode",
          {sw_h, sw_l, u_rst_n, clk_stop}, 1);
    cfg_write(3'd0, 8'd2);
    for (int i = 0; i < 400 && mode != 3'd2; i++) begin
      @(negedge clk);
      if (mode == 3'd0 && sw_h) saw_init = 1'b1;
    end
    wait_quiet();
    check(saw_init, "R9 off exits via init", saw_init, 1);
    check(mode == 3'd2 && sw_l, "R9 final mode", mode, 2);
  endtask

  task automatic hop_count(input logic [7:0] duty, output int hi);
    cfg_write(3'd2, duty);
    go_mode(3'd3);
    hi = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sw_h) hi++;
    end
    go_mode(3'd2);
  endtask

  task automatic t_hop();
    int hi;
    cfg_write(3'd1, 8'd40);
    hop_count(8'd30, hi);
    check(hi >= 260 && hi <= 340, "R10 duty 30/40", hi, 300);
    hop_count(8'd10, hi);
    check(hi >= 60 && hi <= 140, "R10 duty 10/40", hi, 100);
    hop_count(8'd0, hi);
    check(hi == 0, "R10 duty zero", hi, 0);
    hop_count(8'd50, hi);
    check(hi == 400, "R10 duty above period", hi, 400);
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    mon_on = 1'b1;
    t_regs();
    t_high_low();
    t_illegal();
    t_pending();
    t_off();
    t_hop();
    check(both_cnt == 0, "R4 both switches", both_cnt, 0);
    check(bare_cnt == 0, "R5 switch without pause", bare_cnt, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule